// File: doc/BRIEF.md
# Ethernet Descriptor Ring Engine

This block owns the buffer descriptor rings of a small Ethernet MAC. All descriptors sit in one internal register memory. Each descriptor holds two 32-bit words: a status word at the even word address, with the frame length in bits 31:16, and a buffer address word at the odd word address. The transmit ring occupies the low indices. The receive ring starts at the index given by a programmable TX count. Software reaches descriptors and control registers through a simple write port with a combinational read.

An ownership bit in each status word (bit 15) hands a descriptor between software and hardware. For transmit, the engine walks the ring in order. It offers each ready buffer to a transmit stub, waits for that stub's completion pulse, then returns the descriptor to software along with a 4-bit result code. For receive, each frame reported by a receive stub is written into the current empty descriptor together with its length and seven error flags. When no empty descriptor is available, a busy event is raised instead. Events collect in a write-one-to-clear source register, and a mask register gates them onto a single interrupt line.

Status bits shared by both rings: bit 15 is ownership (ready for TX, empty for RX), bit 14 is the per-descriptor interrupt enable, and bit 13 is wrap. Address map (`sw_addr`, 6 bits at default size): word address `2*index + w`, where w=0 is status and w=1 is buffer address. With bit 5 set, offset 0 is the TX count, offset 1 is the event source register and offset 2 is the event mask.

Top module: `bd_ring_engine`

## Requirements
- R1: After reset both ring pointers are at the first slot of their rings, every descriptor word reads 0, the TX count reads TX_DEF (8), the event source register reads 0, and `tx_req` and `irq` are low.
- R2: Software writes to word address 2*index+w land in that descriptor word and read back unchanged. A TX count write above NUM_BD (16) is stored as NUM_BD.
- R3: When the TX descriptor at the ring pointer has bit 15 set, `tx_req` rises and presents that descriptor's buffer address and status bits 31:16. After `tx_done` the descriptor's bit 15 reads 0, bits 3:0 hold `tx_result`, and all other bits are unchanged.
- R4: TX descriptors are served strictly in ring order. A descriptor whose bit 15 is clear stalls the ring, even when later descriptors are ready.
- R5: After completing a TX descriptor with bit 13 set (or the last slot below the TX count), the TX pointer returns to descriptor 0. A ready descriptor beyond the wrap point is never served.
- R6: Completing a TX descriptor whose bit 14 is set raises event bit 0 when `tx_result` is 0, and event bit 1 otherwise. With bit 14 clear, no event is raised.
- R7: The RX ring starts at index equal to the TX count. A frame taken into an empty descriptor (bit 15 set) writes `rx_len` to bits 31:16 and `rx_errs` to bits 6:0, clears bit 15, and keeps bits 14:7. `rx_buf_addr` shows the buffer address of the current RX descriptor.
- R8: After filling an RX descriptor with bit 13 set, the RX pointer returns to the first RX index.
- R9: A filled RX descriptor with bit 14 set raises event bit 2 when `rx_errs` is 0, and event bit 3 otherwise. With bit 14 clear, no event is raised.
- R10: A frame arriving while the current RX descriptor is not empty raises event bit 4, leaves every descriptor unchanged, and does not move the RX pointer.
- R11: Writing ones to the event source register clears those bits. An event arriving in the same cycle as the clear stays set.
- R12: `irq` is high exactly when some event source bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write strobe |
| sw_addr | input | 6 | Word address; top bit selects control registers |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Combinational read data at `sw_addr` |
| tx_req | output | 1 | Transmit stub request, held until `tx_done` |
| tx_buf_addr | output | 32 | Buffer address of the frame being sent |
| tx_len | output | 16 | Length of the frame being sent |
| tx_done | input | 1 | One-cycle completion pulse from the transmit stub |
| tx_result | input | 4 | Transmit result code, 0 meaning success, valid with `tx_done` |
| rx_valid | input | 1 | One-cycle pulse: a received frame is complete |
| rx_len | input | 16 | Length of the received frame |
| rx_errs | input | 7 | Receive error flags of the frame |
| rx_buf_addr | output | 32 | Buffer address of the current RX descriptor |
| irq | output | 1 | Masked interrupt output |

## Verification
The hardest situation to reach from the ports is a receive event landing in the same cycle as a software clear of that same event bit. The bench reaches it by arming an RX descriptor with its interrupt bit set, then driving the `rx_valid` pulse and the write-one-to-clear of all source bits on the same falling edge, so both are sampled by one rising edge. A second hard case is a ready TX descriptor sitting past a wrap point while the one at the pointer is not ready. The bench builds it by marking a descriptor ready behind a wrapped descriptor and watching `tx_req` stay low for many cycles.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
    // status word fields
    localparam int LEN_LSB  = 16;
    localparam int OWN_BIT  = 15;   // TX: ready, RX: empty
    localparam int IRQ_BIT  = 14;
    localparam int WRAP_BIT = 13;
    localparam int TX_RES_W = 4;
    localparam int RX_ERR_W = 7;

    // event source bit positions
    localparam int NEV       = 5;
    localparam int EV_TX_OK  = 0;
    localparam int EV_TX_ERR = 1;
    localparam int EV_RX_OK  = 2;
    localparam int EV_RX_ERR = 3;
    localparam int EV_NOBUF  = 4;

    // control register offsets
    localparam logic [1:0] REG_TXCNT = 2'd0;
    localparam logic [1:0] REG_SRC   = 2'd1;
    localparam logic [1:0] REG_MASK  = 2'd2;
endpackage

// File: rtl/bd_tx_walker.sv
module bd_tx_walker
    import bd_ring_pkg::*;
#(
    parameter int NUM_BD = 16,
    parameter int IW     = $clog2(NUM_BD)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IW:0]         tx_cnt,
    input  logic [31:0]         cur_stat,
    input  logic [31:0]         cur_baddr,
    input  logic                tx_done,
    input  logic [TX_RES_W-1:0] tx_result,
    output logic [IW-1:0]       ptr,
    output logic                tx_req,
    output logic [31:0]         tx_addr,
    output logic [15:0]         tx_len,
    output logic                wr_en,
    output logic [IW-1:0]       wr_idx,
    output logic [31:0]         wr_data,
    output logic                ev_ok,
    output logic                ev_err
);
    typedef struct packed {
        logic          busy;
        logic [IW-1:0] ptr;
        logic [31:0]   stat;
        logic [31:0]   baddr;
    } walk_t;

    walk_t w_q, w_d;

    always_comb begin
        w_d     = w_q;
        wr_en   = 1'b0;
        wr_idx  = w_q.ptr;
        wr_data = w_q.stat;
        ev_ok   = 1'b0;
        ev_err  = 1'b0;
        if (!w_q.busy) begin
            if (({1'b0, w_q.ptr} < tx_cnt) && cur_stat[OWN_BIT]) begin
                w_d.busy  = 1'b1;
                w_d.stat  = cur_stat;
                w_d.baddr = cur_baddr;
            end
        end else if (tx_done) begin
            wr_en                   = 1'b1;
            wr_data[OWN_BIT]        = 1'b0;
            wr_data[TX_RES_W-1:0]   = tx_result;
            if (w_q.stat[IRQ_BIT]) begin
                ev_ok  = (tx_result == '0);
                ev_err = (tx_result != '0);
            end
            w_d.busy = 1'b0;
            if (w_q.stat[WRAP_BIT] || ({1'b0, w_q.ptr} == tx_cnt - 1'b1))
                w_d.ptr = '0;
            else
                w_d.ptr = w_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign ptr     = w_q.ptr;
    assign tx_req  = w_q.busy;
    assign tx_addr = w_q.baddr;
    assign tx_len  = w_q.stat[31:LEN_LSB];

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done) |=> (tx_req && $stable(tx_addr) && $stable(tx_len)));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_req && tx_done) |=> $stable(ptr));
endmodule

// File: rtl/bd_rx_filler.sv
module bd_rx_filler
    import bd_ring_pkg::*;
#(
    parameter int NUM_BD = 16,
    parameter int IW     = $clog2(NUM_BD)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IW:0]         tx_cnt,
    input  logic [31:0]         cur_stat,
    input  logic                rx_valid,
    input  logic [15:0]         rx_len,
    input  logic [RX_ERR_W-1:0] rx_errs,
    output logic [IW-1:0]       abs_idx,
    output logic                abs_ok,
    output logic                wr_en,
    output logic [31:0]         wr_data,
    output logic                ev_ok,
    output logic                ev_err,
    output logic                ev_busy
);
    localparam logic [IW:0] LAST_SLOT = (IW+1)'(NUM_BD - 1);
    localparam logic [IW:0] SLOTS     = (IW+1)'(NUM_BD);

    typedef struct packed {
        logic [IW-1:0] ridx;
    } fill_t;

    fill_t f_q, f_d;
    logic [IW:0] abs_w;

    assign abs_w   = tx_cnt + {1'b0, f_q.ridx};
    assign abs_ok  = (abs_w < SLOTS);
    assign abs_idx = abs_w[IW-1:0];

    always_comb begin
        f_d     = f_q;
        wr_en   = 1'b0;
        wr_data = cur_stat;
        ev_ok   = 1'b0;
        ev_err  = 1'b0;
        ev_busy = 1'b0;
        if (rx_valid) begin
            if (abs_ok && cur_stat[OWN_BIT]) begin
                wr_en                  = 1'b1;
                wr_data[31:LEN_LSB]    = rx_len;
                wr_data[OWN_BIT]       = 1'b0;
                wr_data[RX_ERR_W-1:0]  = rx_errs;
                if (cur_stat[IRQ_BIT]) begin
                    ev_ok  = (rx_errs == '0);
                    ev_err = (rx_errs != '0);
                end
                if (cur_stat[WRAP_BIT] || (abs_w == LAST_SLOT))
                    f_d.ridx = '0;
                else
                    f_d.ridx = f_q.ridx + 1'b1;
            end else begin
                ev_busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_busy |=> $stable(f_q.ridx));
endmodule

// File: rtl/bd_irq_ctrl.sv
module bd_irq_ctrl #(
    parameter int NEV = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev,
    input  logic           clr_we,
    input  logic           msk_we,
    input  logic [NEV-1:0] wdata,
    output logic [NEV-1:0] src,
    output logic [NEV-1:0] mask,
    output logic           irq
);
    typedef struct packed {
        logic [NEV-1:0] src;
        logic [NEV-1:0] mask;
    } irq_t;

    irq_t i_q, i_d;

    always_comb begin
        i_d = i_q;
        if (clr_we) i_d.src = i_q.src & ~wdata;
        i_d.src = i_d.src | ev;
        if (msk_we) i_d.mask = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign src  = i_q.src;
    assign mask = i_q.mask;
    assign irq  = |(i_q.src & i_q.mask);

    // R11
    src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(i_q.src & ~i_d.src)) |-> clr_we);

    // R11
    event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((src & $past(ev)) == $past(ev)));
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine
    import bd_ring_pkg::*;
#(
    parameter int NUM_BD = 16,
    parameter int TX_DEF = 8,
    parameter int IW     = $clog2(NUM_BD),
    parameter int WW     = IW + 1,
    parameter int AW     = WW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_we,
    input  logic [AW-1:0]       sw_addr,
    input  logic [31:0]         sw_wdata,
    output logic [31:0]         sw_rdata,
    output logic                tx_req,
    output logic [31:0]         tx_buf_addr,
    output logic [15:0]         tx_len,
    input  logic                tx_done,
    input  logic [TX_RES_W-1:0] tx_result,
    input  logic                rx_valid,
    input  logic [15:0]         rx_len,
    input  logic [RX_ERR_W-1:0] rx_errs,
    output logic [31:0]         rx_buf_addr,
    output logic                irq
);
    localparam logic [IW:0] MAX_CNT = (IW+1)'(NUM_BD);

    typedef struct packed {
        logic [2*NUM_BD-1:0][31:0] mem;
        logic [IW:0]               tx_cnt;
    } top_t;

    top_t t_q, t_d;

    logic                is_ctrl;
    logic [1:0]          reg_sel;
    logic [IW-1:0]       tx_ptr, tx_wr_idx, rx_idx;
    logic                tx_wr_en, rx_wr_en, rx_ok;
    logic [31:0]         tx_wr_data, rx_wr_data, rx_stat;
    logic [NEV-1:0]      ev, ev_src, ev_mask;
    logic                tx_ev_ok, tx_ev_err, rx_ev_ok, rx_ev_err, rx_ev_busy;

    assign is_ctrl = sw_addr[AW-1];
    assign reg_sel = sw_addr[1:0];

    bd_tx_walker #(.NUM_BD(NUM_BD), .IW(IW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_cnt    (t_q.tx_cnt),
        .cur_stat  (t_q.mem[{tx_ptr, 1'b0}]),
        .cur_baddr (t_q.mem[{tx_ptr, 1'b1}]),
        .tx_done   (tx_done),
        .tx_result (tx_result),
        .ptr       (tx_ptr),
        .tx_req    (tx_req),
        .tx_addr   (tx_buf_addr),
        .tx_len    (tx_len),
        .wr_en     (tx_wr_en),
        .wr_idx    (tx_wr_idx),
        .wr_data   (tx_wr_data),
        .ev_ok     (tx_ev_ok),
        .ev_err    (tx_ev_err)
    );

    assign rx_stat = rx_ok ? t_q.mem[{rx_idx, 1'b0}] : 32'd0;

    bd_rx_filler #(.NUM_BD(NUM_BD), .IW(IW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_cnt   (t_q.tx_cnt),
        .cur_stat (rx_stat),
        .rx_valid (rx_valid),
        .rx_len   (rx_len),
        .rx_errs  (rx_errs),
        .abs_idx  (rx_idx),
        .abs_ok   (rx_ok),
        .wr_en    (rx_wr_en),
        .wr_data  (rx_wr_data),
        .ev_ok    (rx_ev_ok),
        .ev_err   (rx_ev_err),
        .ev_busy  (rx_ev_busy)
    );

    always_comb begin
        ev            = '0;
        ev[EV_TX_OK]  = tx_ev_ok;
        ev[EV_TX_ERR] = tx_ev_err;
        ev[EV_RX_OK]  = rx_ev_ok;
        ev[EV_RX_ERR] = rx_ev_err;
        ev[EV_NOBUF]  = rx_ev_busy;
    end

    bd_irq_ctrl #(.NEV(NEV)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .clr_we (sw_we && is_ctrl && (reg_sel == REG_SRC)),
        .msk_we (sw_we && is_ctrl && (reg_sel == REG_MASK)),
        .wdata  (sw_wdata[NEV-1:0]),
        .src    (ev_src),
        .mask   (ev_mask),
        .irq    (irq)
    );

    // software writes first, engine status updates take precedence
    always_comb begin
        t_d = t_q;
        if (sw_we && !is_ctrl)
            t_d.mem[sw_addr[WW-1:0]] = sw_wdata;
        if (sw_we && is_ctrl && (reg_sel == REG_TXCNT))
            t_d.tx_cnt = (sw_wdata > 32'(NUM_BD)) ? MAX_CNT : sw_wdata[IW:0];
        if (tx_wr_en)
            t_d.mem[{tx_wr_idx, 1'b0}] = tx_wr_data;
        if (rx_wr_en)
            t_d.mem[{rx_idx, 1'b0}] = rx_wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.mem    <= '0;
            t_q.tx_cnt <= (IW+1)'(TX_DEF);
        end else begin
            t_q <= t_d;
        end
    end

    always_comb begin
        sw_rdata = 32'd0;
        if (is_ctrl) begin
            case (reg_sel)
                REG_TXCNT: sw_rdata = 32'(t_q.tx_cnt);
                REG_SRC:   sw_rdata = 32'(ev_src);
                REG_MASK:  sw_rdata = 32'(ev_mask);
                default:   sw_rdata = 32'd0;
            endcase
        end else begin
            sw_rdata = t_q.mem[sw_addr[WW-1:0]];
        end
    end

    assign rx_buf_addr = rx_ok ? t_q.mem[{rx_idx, 1'b1}] : 32'd0;

    // R3
    tx_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_en |=> !t_q.mem[{$past(tx_wr_idx), 1'b0}][OWN_BIT]);

    // R7
    rx_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr_en |=> !t_q.mem[{$past(rx_idx), 1'b0}][OWN_BIT]);
endmodule

// File: tb/sim_bd_ring_engine.sv
module sim_bd_ring_engine;
    localparam int NBD = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [5:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        tx_req;
    logic [31:0] tx_buf_addr;
    logic [15:0] tx_len;
    logic        tx_done = 1'b0;
    logic [3:0]  tx_result = '0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_len = '0;
    logic [6:0]  rx_errs = '0;
    logic [31:0] rx_buf_addr;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bd_ring_engine #(.NUM_BD(NBD), .TX_DEF(8)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .tx_req(tx_req),
        .tx_buf_addr(tx_buf_addr), .tx_len(tx_len), .tx_done(tx_done),
        .tx_result(tx_result), .rx_valid(rx_valid), .rx_len(rx_len),
        .rx_errs(rx_errs), .rx_buf_addr(rx_buf_addr), .irq(irq)
    );

    localparam logic [31:0] OWN = 32'h8000;
    localparam logic [31:0] IEN = 32'h4000;
    localparam logic [31:0] WRP = 32'h2000;

    function automatic logic [5:0] da(input int idx, input int w);
        return 6'(idx * 2 + w);
    endfunction

    function automatic logic [5:0] ca(input int off);
        return 6'(32 + off);
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        sw_addr = a;
        #1;
        d = sw_rdata;
    endtask

    task automatic rd_chk(input string rq, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(rq, v, exp);
    endtask

    task automatic tx_serve(input string rq, input logic [31:0] ea, input logic [15:0] el,
                            input logic [3:0] res);
        int n = 0;
        while (!tx_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk({rq, " tx_req"}, 32'(tx_req), 32'd1);
        chk({rq, " tx_buf_addr"}, tx_buf_addr, ea);
        chk({rq, " tx_len"}, 32'(tx_len), 32'(el));
        tx_done = 1'b1; tx_result = res;
        @(negedge clk);
        tx_done = 1'b0; tx_result = '0;
    endtask

    task automatic rx_frame(input logic [15:0] len, input logic [6:0] errs);
        @(negedge clk);
        rx_valid = 1'b1; rx_len = len; rx_errs = errs;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 tx_req", 32'(tx_req), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        rd_chk("R1 tx count", ca(0), 32'd8);
        rd_chk("R1 src", ca(1), 32'd0);
        rd_chk("R1 desc0 status", da(0, 0), 32'd0);
        chk("R1 rx_buf_addr", rx_buf_addr, 32'd0);
    endtask

    task automatic t_regmap;
        wr(da(7, 1), 32'hCAFE_0123);
        rd_chk("R2 readback", da(7, 1), 32'hCAFE_0123);
        wr(ca(0), 32'd40);
        rd_chk("R2 clamp", ca(0), 32'd16);
        wr(ca(0), 32'd4);
        rd_chk("R2 tx count", ca(0), 32'd4);
    endtask

    task automatic t_tx_basic;
        wr(da(0, 1), 32'h0000_1000);
        wr(da(0, 0), (32'd60 << 16) | OWN | IEN);
        tx_serve("R3 desc0", 32'h1000, 16'd60, 4'd0);
        rd_chk("R3 desc0 returned", da(0, 0), (32'd60 << 16) | IEN);
        rd_chk("R6 tx ok event", ca(1), 32'h01);
        wr(ca(1), 32'h01);
        rd_chk("R11 cleared", ca(1), 32'h00);
    endtask

    task automatic t_tx_error;
        wr(da(1, 1), 32'h0000_2000);
        wr(da(1, 0), (32'd100 << 16) | OWN | IEN);
        tx_serve("R3 desc1", 32'h2000, 16'd100, 4'd5);
        rd_chk("R3 desc1 result", da(1, 0), (32'd100 << 16) | IEN | 32'd5);
        rd_chk("R6 tx err event", ca(1), 32'h02);
        wr(ca(1), 32'h1F);
    endtask

    task automatic t_tx_order_wrap;
        bit stayed = 1'b1;
        wr(da(3, 1), 32'h0000_4000);
        wr(da(3, 0), (32'd40 << 16) | OWN);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (tx_req) stayed = 1'b0;
        end
        chk("R4 stall on not-ready desc2", 32'(stayed), 32'd1);
        wr(da(2, 1), 32'h0000_3000);
        wr(da(2, 0), (32'd200 << 16) | OWN | WRP);
        tx_serve("R4 desc2 next", 32'h3000, 16'd200, 4'd0);
        rd_chk("R6 no event without irq bit", ca(1), 32'h00);
        stayed = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (tx_req) stayed = 1'b0;
        end
        chk("R5 no service past wrap", 32'(stayed), 32'd1);
        rd_chk("R5 desc3 still ready", da(3, 0), (32'd40 << 16) | OWN);
        wr(da(0, 0), (32'd60 << 16) | OWN);
        tx_serve("R5 wrapped to desc0", 32'h1000, 16'd60, 4'd0);
        rd_chk("R3 desc0 second", da(0, 0), 32'd60 << 16);
    endtask

    task automatic t_rx_basic;
        wr(da(4, 1), 32'h0000_8000);
        wr(da(4, 0), OWN | IEN);
        wr(da(5, 1), 32'h0000_9000);
        wr(da(5, 0), OWN | IEN | WRP);
        chk("R7 rx_buf_addr base", rx_buf_addr, 32'h8000);
        rx_frame(16'd64, 7'd0);
        rd_chk("R7 desc4 filled", da(4, 0), (32'd64 << 16) | IEN);
        rd_chk("R9 rx ok event", ca(1), 32'h04);
        chk("R7 rx_buf_addr next", rx_buf_addr, 32'h9000);
        wr(ca(1), 32'h04);
        rx_frame(16'd1600, 7'h12);
        rd_chk("R7 desc5 errors", da(5, 0), (32'd1600 << 16) | IEN | WRP | 32'h12);
        rd_chk("R9 rx err event", ca(1), 32'h08);
        wr(ca(1), 32'h08);
        chk("R8 wrapped to rx base", rx_buf_addr, 32'h8000);
    endtask

    task automatic t_rx_busy_mask;
        rx_frame(16'd70, 7'd0);
        rd_chk("R10 desc4 untouched", da(4, 0), (32'd64 << 16) | IEN);
        rd_chk("R10 busy event", ca(1), 32'h10);
        wr(ca(2), 32'h10);
        chk("R12 irq on", 32'(irq), 32'd1);
        wr(ca(2), 32'h0C);
        chk("R12 irq masked", 32'(irq), 32'd0);
        wr(ca(1), 32'h10);
        rd_chk("R11 busy cleared", ca(1), 32'h00);
        wr(da(4, 0), OWN);
        rx_frame(16'd80, 7'd0);
        rd_chk("R10 pointer held at desc4", da(4, 0), 32'd80 << 16);
        rd_chk("R9 no event without irq bit", ca(1), 32'h00);
    endtask

    task automatic t_clear_race;
        wr(da(5, 0), OWN | IEN | WRP);
        @(negedge clk);
        rx_valid = 1'b1; rx_len = 16'd90; rx_errs = '0;
        sw_we = 1'b1; sw_addr = ca(1); sw_wdata = 32'h1F;
        @(negedge clk);
        rx_valid = 1'b0; sw_we = 1'b0;
        rd_chk("R11 event wins over clear", ca(1), 32'h04);
        chk("R12 irq from masked-in event", 32'(irq), 32'd1);
        rd_chk("R7 desc5 refilled", da(5, 0), (32'd90 << 16) | IEN | WRP);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_tx_basic();
        t_tx_error();
        t_tx_order_wrap();
        t_rx_basic();
        t_rx_busy_mask();
        t_clear_race();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule